// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver Sequencer

This block sequences the drive levels for a passive LCD panel that is multiplexed over four common lines and eighteen segment lines, so that up to 72 segments can be lit. It reads a 72-bit segment bitmap and, for every common and every segment pin, produces a 2-bit level code. An external analog stage turns each code into ground, half supply or full supply. The drive scheme is 1/4 duty with 1/2 bias. The polarity alternates from frame to frame, so every pin averages to the half level and the panel sees no DC.

A step tick, nominally every 2 ms, advances the scan by one common slot. After reset, and again after a clock stop ends, the block holds every pin at the half level with its blank flag raised. The flag clears on the next step tick, and the regular waveforms begin at that point. While the clock-stop input is high, every pin is driven to ground. When the display-enable input is low, every pin rests at the half level and the scan keeps running.

Top module: `lcd_mux_driver`

## Requirements
- R1: Level codes are 2'b00 for ground, 2'b01 for half and 2'b10 for full. No pin ever carries 2'b11.
- R2: After reset, every common and segment pin reads half and `blank_o` reads 1, for as long as no step tick arrives. The first step tick clears `blank_o` and starts the scan in slot 0 with positive polarity.
- R3: While the scan runs, common k is active in slot k. The slot advances by one on each step tick and wraps from 3 to 0. The active common is full in even frames and ground in odd frames, and the frame parity toggles after slot 3. All other commons read half.
- R4: For segment s in slot c, the bitmap bit used is `seg_map[c*18+s]`. A set bit drives the segment to the rail opposite the active common, and a clear bit drives it to the same rail as the active common.
- R5: While the scan runs and `disp_en` is 0, every pin reads half in the same cycle, and the scan keeps advancing on step ticks.
- R6: While `clk_stop` is 1, every pin reads ground in the same cycle, and `blank_o` is 1 from the next clock on. After `clk_stop` falls, the pins read half from the second clock on, until a step tick restarts the scan as in R2.
- R7: With a fixed bitmap, the sum of level codes on each pin over any eight consecutive scan steps is 8, which is an average of half.
- R8: Without a step tick, the slot and the frame parity hold, so every output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | One-cycle pulse that advances the scan by one step |
| disp_en | input | 1 | Display enable; when 0, all pins rest at half |
| clk_stop | input | 1 | Clock-stop request; when 1, all pins are driven to ground |
| seg_map | input | 72 | Segment bitmap, bit c*18+s = segment s under common c |
| com_lvl | output | 8 | Common level codes, common k at bits 2k+1:2k |
| seg_lvl | output | 36 | Segment level codes, segment s at bits 2s+1:2s |
| blank_o | output | 1 | Display-off flag, high until the scan starts |

## Verification
The level outputs are combinational from the scan registers and from `seg_map`, `disp_en` and `clk_stop`. A change on any of those three inputs therefore shows on the pins in the same cycle. A step tick shows on the pins after the clock edge that samples it. `blank_o` follows `clk_stop` one clock late, and a released stop needs one further clock before the pins leave ground. The bench drives every input on the falling edge and compares all pins against its own model shortly afterwards. That model updates only at rising edges, so each comparison falls in the cycle where the result is due. The two-frame average is checked by adding up the observed codes over eight ticks for each of several bitmaps.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    localparam logic [1:0] LVL_GND  = 2'b00;
    localparam logic [1:0] LVL_HALF = 2'b01;
    localparam logic [1:0] LVL_FULL = 2'b10;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic stop;
        logic run;
        logic pol;
    } drive_ctx_t;

    function automatic logic [1:0] com_rail(input logic pol);
        return pol ? LVL_GND : LVL_FULL;
    endfunction

    function automatic logic [1:0] seg_rail(input logic on, input logic pol);
        return (on ^ pol) ? LVL_GND : LVL_FULL;
    endfunction

    function automatic logic [1:0] rest_level(input drive_ctx_t ctx);
        return ctx.stop ? LVL_GND : LVL_HALF;
    endfunction

endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
    import lcd_mux_pkg::*;
#(
    parameter int NUM_COM = 4,
    localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_tick,
    input  logic              clk_stop,
    output drive_ctx_t        ctx,
    output logic [SLOT_W-1:0] slot,
    output logic              blank
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_COM - 1);

    seq_state_e st;
    logic       pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_PRIME;
            slot  <= '0;
            pol   <= 1'b0;
            blank <= 1'b1;
        end else if (clk_stop) begin
            st    <= ST_STOP;
            slot  <= '0;
            pol   <= 1'b0;
            blank <= 1'b1;
        end else begin
            case (st)
                ST_STOP: st <= ST_PRIME;
                ST_PRIME: begin
                    if (step_tick) begin
                        st    <= ST_RUN;
                        slot  <= '0;
                        pol   <= 1'b0;
                        blank <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (step_tick) begin
                        if (slot == LAST_SLOT) begin
                            slot <= '0;
                            pol  <= ~pol;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                default: st <= ST_PRIME;
            endcase
        end
    end

    always_comb begin
        ctx.stop = clk_stop || (st == ST_STOP);
        ctx.run  = !clk_stop && (st == ST_RUN);
        ctx.pol  = pol;
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && step_tick && !clk_stop && slot == LAST_SLOT) |=> (slot == '0 && pol != $past(pol)))
        else $error("slot wrap without parity toggle"); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !step_tick && !clk_stop) |=> ($stable(slot) && $stable(pol)))
        else $error("scan moved without tick"); // R8

    AST_BLANK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> ($past(step_tick) && !$past(clk_stop)))
        else $error("blank cleared without tick"); // R2

    AST_STOP_BLANK: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> blank)
        else $error("blank low after stop"); // R6

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcd_mux_pkg::*;
#(
    parameter int NUM_COM = 4,
    localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  drive_ctx_t          ctx,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                disp_en,
    output logic [2*NUM_COM-1:0] com_lvl
);
    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        always_comb begin
            if (ctx.run && disp_en && slot == SLOT_W'(k))
                com_lvl[2*k +: 2] = com_rail(ctx.pol);
            else
                com_lvl[2*k +: 2] = rest_level(ctx);
        end
    end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_mux_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 18,
    localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
    localparam int MAP_W  = NUM_COM * NUM_SEG
) (
    input  drive_ctx_t           ctx,
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 disp_en,
    input  logic [MAP_W-1:0]     seg_map,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    logic [NUM_SEG-1:0] row;

    always_comb begin
        row = '0;
        for (int c = 0; c < NUM_COM; c++) begin
            if (slot == SLOT_W'(c))
                row = seg_map[c*NUM_SEG +: NUM_SEG];
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_comb begin
            if (ctx.run && disp_en)
                seg_lvl[2*s +: 2] = seg_rail(row[s], ctx.pol);
            else
                seg_lvl[2*s +: 2] = rest_level(ctx);
        end
    end
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_mux_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 18,
    localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
    localparam int MAP_W  = NUM_COM * NUM_SEG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_tick,
    input  logic                 disp_en,
    input  logic                 clk_stop,
    input  logic [MAP_W-1:0]     seg_map,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl,
    output logic                 blank_o
);
    drive_ctx_t        ctx;
    logic [SLOT_W-1:0] slot;

    lcd_seq_ctrl #(.NUM_COM(NUM_COM)) u_seq (
        .clk(clk), .rst(rst), .step_tick(step_tick), .clk_stop(clk_stop),
        .ctx(ctx), .slot(slot), .blank(blank_o)
    );

    lcd_com_drive #(.NUM_COM(NUM_COM)) u_com (
        .ctx(ctx), .slot(slot), .disp_en(disp_en), .com_lvl(com_lvl)
    );

    lcd_seg_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seg (
        .ctx(ctx), .slot(slot), .disp_en(disp_en), .seg_map(seg_map),
        .seg_lvl(seg_lvl)
    );

    logic [NUM_COM-1:0] com_active;
    logic               any_illegal;

    always_comb begin
        any_illegal = 1'b0;
        for (int k = 0; k < NUM_COM; k++) begin
            com_active[k] = (com_lvl[2*k +: 2] != LVL_HALF);
            if (com_lvl[2*k +: 2] == 2'b11) any_illegal = 1'b1;
        end
        for (int s = 0; s < NUM_SEG; s++)
            if (seg_lvl[2*s +: 2] == 2'b11) any_illegal = 1'b1;
    end

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        !any_illegal)
        else $error("level code 11 driven"); // R1

    AST_STOP_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        clk_stop |-> (com_lvl == '0 && seg_lvl == '0))
        else $error("pins not low in clock stop"); // R6

    AST_ONE_ACTIVE_COM: assert property (@(posedge clk) disable iff (rst)
        (ctx.run && disp_en) |-> ($countones(com_active) == 1))
        else $error("not exactly one active common"); // R3

    AST_BLANK_HALF: assert property (@(posedge clk) disable iff (rst)
        (blank_o && !clk_stop && !$past(clk_stop)) |-> ($onehot0(com_active) && com_active == '0))
        else $error("common off half while blanked"); // R2

endmodule

// File: tb/sim_lcd_mux_driver.sv
module sim_lcd_mux_driver;
    localparam int NC = 4;
    localparam int NS = 18;
    localparam int MW = NC * NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_tick = 1'b0;
    logic disp_en = 1'b1;
    logic clk_stop = 1'b0;
    logic [MW-1:0] seg_map = '0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;
    logic blank_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    lcd_mux_driver u0 (
        .clk(clk), .rst(rst), .step_tick(step_tick), .disp_en(disp_en),
        .clk_stop(clk_stop), .seg_map(seg_map), .com_lvl(com_lvl),
        .seg_lvl(seg_lvl), .blank_o(blank_o)
    );

    // Spec model: 0 stopped, 1 priming, 2 running
    int m_st = 1;
    int m_slot = 0;
    int m_pol = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 1; m_slot <= 0; m_pol <= 0;
        end else if (clk_stop) begin
            m_st <= 0; m_slot <= 0; m_pol <= 0;
        end else if (m_st == 0) begin
            m_st <= 1;
        end else if (m_st == 1) begin
            if (step_tick) begin m_st <= 2; m_slot <= 0; m_pol <= 0; end
        end else if (step_tick) begin
            if (m_slot == NC - 1) begin m_slot <= 0; m_pol <= 1 - m_pol; end
            else m_slot <= m_slot + 1;
        end
    end

    function automatic logic [1:0] exp_com(int k);
        if (clk_stop || m_st == 0) return 2'b00;
        if (m_st != 2 || !disp_en || k != m_slot) return 2'b01;
        return (m_pol == 0) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [1:0] exp_seg(int s);
        logic on;
        if (clk_stop || m_st == 0) return 2'b00;
        if (m_st != 2 || !disp_en) return 2'b01;
        on = seg_map[m_slot*NS + s];
        if (m_pol == 0) return on ? 2'b00 : 2'b10;
        return on ? 2'b10 : 2'b00;
    endfunction

    task automatic check_all(input string tag);
        logic [2*NC-1:0] ec;
        logic [2*NS-1:0] es;
        logic eb;
        int bad11;
        for (int k = 0; k < NC; k++) ec[2*k +: 2] = exp_com(k);
        for (int s = 0; s < NS; s++) es[2*s +: 2] = exp_seg(s);
        eb = (m_st != 2);
        checks++;
        if (com_lvl !== ec) begin
            errors++;
            $display("FAIL %s com_lvl actual=%h expected=%h", tag, com_lvl, ec);
        end
        checks++;
        if (seg_lvl !== es) begin
            errors++;
            $display("FAIL %s seg_lvl actual=%h expected=%h", tag, seg_lvl, es);
        end
        checks++;
        if (blank_o !== eb) begin
            errors++;
            $display("FAIL %s blank_o actual=%b expected=%b", tag, blank_o, eb);
        end
        bad11 = 0;
        for (int k = 0; k < NC; k++) if (com_lvl[2*k +: 2] == 2'b11) bad11++;
        for (int s = 0; s < NS; s++) if (seg_lvl[2*s +: 2] == 2'b11) bad11++;
        checks++;
        if (bad11 != 0) begin
            errors++;
            $display("FAIL R1 code 11 lanes actual=%0d expected=0", bad11);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic tick_once();
        @(negedge clk) step_tick = 1'b1;
        @(negedge clk) step_tick = 1'b0;
        #1;
    endtask

    function automatic logic [MW-1:0] pattern(int p);
        logic [MW-1:0] v;
        for (int b = 0; b < MW; b++) begin
            case (p)
                0: v[b] = 1'b0;
                1: v[b] = 1'b1;
                2: v[b] = ((b * 7 + 3) % 5) < 2;
                default: v[b] = (b % NS) == (b / NS) * 3;
            endcase
        end
        return v;
    endfunction

    int sum_c[NC];
    int sum_s[NS];

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R2 reset");
        idle(5);
        check_all("R2 prime hold");
        tick_once();
        check_all("R2 first tick R3");

        for (int p = 0; p < 4; p++) begin
            @(negedge clk) seg_map = pattern(p);
            #1;
            check_all("R4 map change");
            for (int k = 0; k < NC; k++) sum_c[k] = 0;
            for (int s = 0; s < NS; s++) sum_s[s] = 0;
            for (int t = 0; t < 2 * NC; t++) begin
                tick_once();
                check_all("R3 R4 scan");
                for (int k = 0; k < NC; k++) sum_c[k] += int'(com_lvl[2*k +: 2]);
                for (int s = 0; s < NS; s++) sum_s[s] += int'(seg_lvl[2*s +: 2]);
            end
            for (int k = 0; k < NC; k++) begin
                checks++;
                if (sum_c[k] != 2 * NC) begin
                    errors++;
                    $display("FAIL R7 com %0d sum actual=%0d expected=%0d", k, sum_c[k], 2 * NC);
                end
            end
            for (int s = 0; s < NS; s++) begin
                checks++;
                if (sum_s[s] != 2 * NC) begin
                    errors++;
                    $display("FAIL R7 seg %0d sum actual=%0d expected=%0d", s, sum_s[s], 2 * NC);
                end
            end
        end

        tick_once();
        begin
            logic [2*NC-1:0] hc;
            logic [2*NS-1:0] hs;
            hc = com_lvl; hs = seg_lvl;
            idle(10);
            checks++;
            if (com_lvl !== hc || seg_lvl !== hs) begin
                errors++;
                $display("FAIL R8 hold actual=%h/%h expected=%h/%h", com_lvl, seg_lvl, hc, hs);
            end
            check_all("R8 hold model");
        end

        @(negedge clk) disp_en = 1'b0;
        #1;
        check_all("R5 disable");
        tick_once();
        check_all("R5 disabled tick");
        tick_once();
        @(negedge clk) disp_en = 1'b1;
        #1;
        check_all("R5 reenable");

        @(negedge clk) clk_stop = 1'b1;
        #1;
        check_all("R6 stop same cycle");
        idle(1);
        check_all("R6 stop blank");
        tick_once();
        check_all("R6 tick in stop");
        @(negedge clk) clk_stop = 1'b0;
        #1;
        check_all("R6 release cycle");
        idle(1);
        check_all("R6 prime half");
        idle(3);
        check_all("R6 prime hold");
        tick_once();
        check_all("R6 restart R2");
        tick_once();
        check_all("R6 restart step");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule